// File: doc/BRIEF.md
# Single-Level Page Table Walker

This block turns a virtual address into a physical address by fetching one entry from a flat page table in memory. Software programs the physical base of the table through a plain write port. Each request carries a 32-bit virtual address and an access kind. The walker takes the upper 20 bits of the address as the page number. It reads the 4-byte entry at `base + page_number * 4` and checks that the entry is present and allows the access. It then answers with either a physical address and a cacheable flag, or a fault code.

On a successful translation the walker marks the entry as used, and on a successful write it also marks the entry as modified. When either mark changes, it writes the updated entry back to the same memory word before it responds. Only one translation is in flight at a time.

Four ports use valid/ready handshakes: request, memory read, memory write and response. A transfer takes place on a rising clock edge where both valid and ready are high. Once valid is raised, it stays high and the payload stays unchanged until that edge. The memory read data comes back as a single-cycle `mem_rd_data_valid` pulse, which the walker always accepts. Back-pressure on `rsp_ready` holds the walker in its respond state and keeps `req_ready` low. Back-pressure on `mem_rd_ready` or `mem_wr_ready` stalls the walk in place.

Top module: `pt_walker`

## Requirements
- R1: `req_ready` is high only while no translation is in progress. A request is taken on an edge where `req_valid` and `req_ready` are both high, and `req_ready` stays low from then until the response transfer completes.
- R2: The table base resets to 0 and is loaded from `base_wdata` on any edge where `base_we` is high. The entry address equals base + (vaddr[31:12] << 2), taken modulo 2^32. The base used is the value held at the edge that accepts the request, so a later base write does not affect a translation already in progress.
- R3: Exactly one memory read is issued per translation, at the entry address. `mem_rd_valid` and `mem_rd_addr` hold steady until `mem_rd_ready`. The entry is captured from the `mem_rd_data_valid` pulse.
- R4: Entry layout: frame number in bits 31:12, present in bit 11, cacheable in bit 5, execute in bit 4, write in bit 3, read in bit 2, modified in bit 1, used in bit 0. Bits 10:6 are carried through unchanged on write-back.
- R5: If the present bit is 0, the response has `rsp_fault` = 1 (page fault), `rsp_paddr` = 0 and `rsp_cacheable` = 0, whatever the permission bits. No memory write takes place.
- R6: Access kinds are encoded 0 = read, 1 = write, 2 = execute. If the entry is present but the permission bit for the kind is 0, or the kind is 3, the response has `rsp_fault` = 2 (protection fault), `rsp_paddr` = 0 and `rsp_cacheable` = 0. No memory write takes place.
- R7: On success `rsp_fault` = 0, `rsp_paddr` = {frame number, vaddr[11:0]}, and `rsp_cacheable` equals the entry's cacheable bit.
- R8: On success the updated entry has the used bit set, and on a successful write also the modified bit. Exactly one write of the updated entry goes to the entry address, and only when it differs from the fetched entry. That write completes before the response is raised.
- R9: `rsp_valid` and all response fields, and `mem_wr_valid` with its address and data, hold steady until their ready is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| base_we | input | 1 | Load the table base register |
| base_wdata | input | 32 | New table base (physical) |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker idle, request accepted |
| req_vaddr | input | 32 | Virtual address to translate |
| req_kind | input | 2 | Access kind: 0 read, 1 write, 2 execute |
| mem_rd_valid | output | 1 | Entry read request valid |
| mem_rd_ready | input | 1 | Memory accepts the read |
| mem_rd_addr | output | 32 | Entry address |
| mem_rd_data_valid | input | 1 | Entry data pulse |
| mem_rd_data | input | 32 | Fetched entry |
| mem_wr_valid | output | 1 | Entry write-back valid |
| mem_wr_ready | input | 1 | Memory accepts the write |
| mem_wr_addr | output | 32 | Write-back address |
| mem_wr_data | output | 32 | Updated entry |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_paddr | output | 32 | Physical address, 0 on a fault |
| rsp_cacheable | output | 1 | Page may be cached |
| rsp_fault | output | 2 | 0 none, 1 page fault, 2 protection fault |

## Verification
The assertions cover the handshake rules on every cycle. They check that no new request is taken while a walk is in progress, that read, write and response payloads hold under back-pressure, and that a fault always reports a zero address and no caching. They also check that a successful response carries the offset of the accepted request, that the write-back payload has the used bit set, and that the write-back and the response never overlap. Several properties can only be shown by the bench's scenarios, because they depend on the entry memory contents. These are the exact entry address, including wrap-around and a base change in the middle of a walk, and the choice between page fault and protection fault for each kind. They also include whether a write-back happens and the value it leaves in memory.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_kind_e;

  typedef enum logic [1:0] {
    FLT_NONE = 2'd0,
    FLT_PAGE = 2'd1,
    FLT_PROT = 2'd2
  } fault_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ_PTE,
    ST_CHECK,
    ST_WRITEBACK,
    ST_RESPOND
  } walk_state_e;

  // Flag positions inside an entry; the frame number sits at the top.
  localparam int BIT_USED  = 0;
  localparam int BIT_MOD   = 1;
  localparam int BIT_RD    = 2;
  localparam int BIT_WR    = 3;
  localparam int BIT_EX    = 4;
  localparam int BIT_CACHE = 5;
  localparam int BIT_PRES  = 11;

endpackage

// File: rtl/pt_entry_addr.sv
module pt_entry_addr #(
  parameter int PA_W    = 32,
  parameter int VPN_W   = 20,
  parameter int ENT_LOG = 2
) (
  input  logic [PA_W-1:0]  base,
  input  logic [VPN_W-1:0] vpn,
  output logic [PA_W-1:0]  ent_addr
);
  logic [PA_W-1:0] vpn_ext;

  always_comb begin
    vpn_ext  = PA_W'(vpn);
    ent_addr = base + (vpn_ext << ENT_LOG);
  end
endmodule

// File: rtl/pt_entry_eval.sv
module pt_entry_eval import pt_walker_pkg::*; #(
  parameter int PTE_W     = 32,
  parameter int PA_W      = 32,
  parameter int PAGE_BITS = 12
) (
  input  logic [PTE_W-1:0]     pte,
  input  acc_kind_e            kind,
  input  logic [PAGE_BITS-1:0] offset,
  output fault_e               fault,
  output logic [PA_W-1:0]      paddr,
  output logic                 cacheable,
  output logic [PTE_W-1:0]     new_pte,
  output logic                 need_wb
);
  localparam int PFN_W = PA_W - PAGE_BITS;

  logic allowed;

  always_comb begin
    unique case (kind)
      ACC_READ:  allowed = pte[BIT_RD];
      ACC_WRITE: allowed = pte[BIT_WR];
      ACC_EXEC:  allowed = pte[BIT_EX];
      default:   allowed = 1'b0;
    endcase

    if (!pte[BIT_PRES])  fault = FLT_PAGE;
    else if (!allowed)   fault = FLT_PROT;
    else                 fault = FLT_NONE;

    new_pte = pte;
    new_pte[BIT_USED] = 1'b1;
    if (kind == ACC_WRITE) new_pte[BIT_MOD] = 1'b1;

    if (fault == FLT_NONE) begin
      paddr     = {pte[PTE_W-1 -: PFN_W], offset};
      cacheable = pte[BIT_CACHE];
      need_wb   = (new_pte != pte);
    end else begin
      paddr     = '0;
      cacheable = 1'b0;
      need_wb   = 1'b0;
    end
  end
endmodule

// File: rtl/pt_walker.sv
module pt_walker import pt_walker_pkg::*; #(
  parameter int VA_W      = 32,
  parameter int PA_W      = 32,
  parameter int PAGE_BITS = 12,
  parameter int PTE_W     = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             base_we,
  input  logic [PA_W-1:0]  base_wdata,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic [1:0]       req_kind,
  output logic             mem_rd_valid,
  input  logic             mem_rd_ready,
  output logic [PA_W-1:0]  mem_rd_addr,
  input  logic             mem_rd_data_valid,
  input  logic [PTE_W-1:0] mem_rd_data,
  output logic             mem_wr_valid,
  input  logic             mem_wr_ready,
  output logic [PA_W-1:0]  mem_wr_addr,
  output logic [PTE_W-1:0] mem_wr_data,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [PA_W-1:0]  rsp_paddr,
  output logic             rsp_cacheable,
  output logic [1:0]       rsp_fault
);
  localparam int VPN_W   = VA_W - PAGE_BITS;
  localparam int ENT_LOG = $clog2(PTE_W / 8);

  walk_state_e            state_q;
  logic [PA_W-1:0]        base_q;
  logic [PA_W-1:0]        ent_addr_q;
  logic [PAGE_BITS-1:0]   off_q;
  acc_kind_e              kind_q;
  logic                   rd_sent_q;
  logic [PTE_W-1:0]       pte_q;
  logic [PTE_W-1:0]       wb_data_q;
  logic [PA_W-1:0]        paddr_q;
  logic                   cache_q;
  fault_e                 fault_q;

  logic [PA_W-1:0]        ent_addr;
  fault_e                 ev_fault;
  logic [PA_W-1:0]        ev_paddr;
  logic                   ev_cache;
  logic [PTE_W-1:0]       ev_new_pte;
  logic                   ev_need_wb;

  pt_entry_addr #(.PA_W(PA_W), .VPN_W(VPN_W), .ENT_LOG(ENT_LOG)) u_addr (
    .base     (base_q),
    .vpn      (req_vaddr[VA_W-1:PAGE_BITS]),
    .ent_addr (ent_addr)
  );

  pt_entry_eval #(.PTE_W(PTE_W), .PA_W(PA_W), .PAGE_BITS(PAGE_BITS)) u_eval (
    .pte       (pte_q),
    .kind      (kind_q),
    .offset    (off_q),
    .fault     (ev_fault),
    .paddr     (ev_paddr),
    .cacheable (ev_cache),
    .new_pte   (ev_new_pte),
    .need_wb   (ev_need_wb)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       base_q <= '0;
    else if (base_we) base_q <= base_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      ent_addr_q <= '0;
      off_q      <= '0;
      kind_q     <= ACC_READ;
      rd_sent_q  <= 1'b0;
      pte_q      <= '0;
      wb_data_q  <= '0;
      paddr_q    <= '0;
      cache_q    <= 1'b0;
      fault_q    <= FLT_NONE;
    end else begin
      unique case (state_q)
        ST_IDLE: if (req_valid) begin
          ent_addr_q <= ent_addr;
          off_q      <= req_vaddr[PAGE_BITS-1:0];
          kind_q     <= acc_kind_e'(req_kind);
          rd_sent_q  <= 1'b0;
          state_q    <= ST_READ_PTE;
        end
        ST_READ_PTE: begin
          if (!rd_sent_q) begin
            if (mem_rd_ready) rd_sent_q <= 1'b1;
          end else if (mem_rd_data_valid) begin
            pte_q   <= mem_rd_data;
            state_q <= ST_CHECK;
          end
        end
        ST_CHECK: begin
          paddr_q   <= ev_paddr;
          cache_q   <= ev_cache;
          fault_q   <= ev_fault;
          wb_data_q <= ev_new_pte;
          state_q   <= ev_need_wb ? ST_WRITEBACK : ST_RESPOND;
        end
        ST_WRITEBACK: if (mem_wr_ready) state_q <= ST_RESPOND;
        ST_RESPOND:   if (rsp_ready)    state_q <= ST_IDLE;
        default:      state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    req_ready     = (state_q == ST_IDLE);
    mem_rd_valid  = (state_q == ST_READ_PTE) && !rd_sent_q;
    mem_rd_addr   = ent_addr_q;
    mem_wr_valid  = (state_q == ST_WRITEBACK);
    mem_wr_addr   = ent_addr_q;
    mem_wr_data   = wb_data_q;
    rsp_valid     = (state_q == ST_RESPOND);
    rsp_paddr     = paddr_q;
    rsp_cacheable = cache_q;
    rsp_fault     = fault_q;
  end
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
  parameter int VA_W      = 32,
  parameter int PA_W      = 32,
  parameter int PAGE_BITS = 12,
  parameter int PTE_W     = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic [VA_W-1:0]  req_vaddr,
  input logic             mem_rd_valid,
  input logic             mem_rd_ready,
  input logic [PA_W-1:0]  mem_rd_addr,
  input logic             mem_wr_valid,
  input logic             mem_wr_ready,
  input logic [PA_W-1:0]  mem_wr_addr,
  input logic [PTE_W-1:0] mem_wr_data,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic [PA_W-1:0]  rsp_paddr,
  input logic             rsp_cacheable,
  input logic [1:0]       rsp_fault
);
  logic [PAGE_BITS-1:0] off_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      off_seen <= '0;
    else if (req_valid && req_ready) off_seen <= req_vaddr[PAGE_BITS-1:0];
  end

  // R1
  one_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid || mem_rd_valid || mem_wr_valid) |-> !req_ready);

  // R3
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr)));

  // R9
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_valid && !mem_wr_ready) |=>
      (mem_wr_valid && $stable(mem_wr_addr) && $stable(mem_wr_data)));

  // R9
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=>
      (rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault) && $stable(rsp_cacheable)));

  // R5
  fault_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault != 2'd0) |-> (rsp_paddr == '0 && !rsp_cacheable && rsp_fault != 2'd3));

  // R7
  offset_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault == 2'd0) |-> (rsp_paddr[PAGE_BITS-1:0] == off_seen));

  // R8
  wb_used_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_valid |-> (mem_wr_data[0] && !rsp_valid));
endmodule

bind pt_walker pt_walker_chk #(
  .VA_W(VA_W), .PA_W(PA_W), .PAGE_BITS(PAGE_BITS), .PTE_W(PTE_W)
) u_chk (
  .clk(clk), .rst_n(rst_n),
  .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
  .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready), .mem_rd_addr(mem_rd_addr),
  .mem_wr_valid(mem_wr_valid), .mem_wr_ready(mem_wr_ready),
  .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr),
  .rsp_cacheable(rsp_cacheable), .rsp_fault(rsp_fault)
);

// File: tb/pt_walker_bench.sv
module pt_walker_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n;
  logic        base_we;
  logic [31:0] base_wdata;
  logic        req_valid, req_ready;
  logic [31:0] req_vaddr;
  logic [1:0]  req_kind;
  logic        mem_rd_valid, mem_rd_ready;
  logic [31:0] mem_rd_addr;
  logic        mem_rd_data_valid;
  logic [31:0] mem_rd_data;
  logic        mem_wr_valid, mem_wr_ready;
  logic [31:0] mem_wr_addr, mem_wr_data;
  logic        rsp_valid, rsp_ready;
  logic [31:0] rsp_paddr;
  logic        rsp_cacheable;
  logic [1:0]  rsp_fault;

  pt_walker u_pt_walker (
    .clk(clk), .rst_n(rst_n), .base_we(base_we), .base_wdata(base_wdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr), .req_kind(req_kind),
    .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready), .mem_rd_addr(mem_rd_addr),
    .mem_rd_data_valid(mem_rd_data_valid), .mem_rd_data(mem_rd_data),
    .mem_wr_valid(mem_wr_valid), .mem_wr_ready(mem_wr_ready),
    .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr),
    .rsp_cacheable(rsp_cacheable), .rsp_fault(rsp_fault)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [31:0] pte_mem [16];
  logic [31:0] tb_base;
  logic [3:0]  cur_idx;
  logic [1:0]  exp_fault;
  logic [31:0] exp_paddr, exp_pte, exp_ent;
  logic        exp_cache;
  int          exp_wb, wr_count, rd_count, rsp_count;
  int          data_wait;
  bit          rd_pend, wr_pend, rsp_pend;
  logic [31:0] rd_addr_c, wr_addr_c, wr_data_c, rsp_paddr_c;
  logic [1:0]  rsp_fault_c;
  logic        rsp_cache_c;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // Expected outcome from the requirements (R4..R8).
  task automatic set_expect(input logic [31:0] va, input logic [1:0] kind, input logic [31:0] pte);
    logic perm;
    perm = (kind == 2'd0) ? pte[2] : (kind == 2'd1) ? pte[3] : (kind == 2'd2) ? pte[4] : 1'b0;
    exp_ent = tb_base + {10'b0, va[31:12], 2'b00};
    if (!pte[11])   exp_fault = 2'd1;
    else if (!perm) exp_fault = 2'd2;
    else            exp_fault = 2'd0;
    if (exp_fault != 2'd0) begin
      exp_paddr = 32'h0; exp_cache = 1'b0; exp_pte = pte; exp_wb = 0;
    end else begin
      exp_paddr = {pte[31:12], va[11:0]};
      exp_cache = pte[5];
      exp_pte   = pte | 32'h1 | ((kind == 2'd1) ? 32'h2 : 32'h0);
      exp_wb    = (exp_pte != pte) ? 1 : 0;
    end
  endtask

  // Memory and response model, driven away from the active edge.
  initial begin
    mem_rd_ready = 0; mem_wr_ready = 0; rsp_ready = 0;
    mem_rd_data_valid = 0; mem_rd_data = 0;
    data_wait = -1; rd_pend = 0; wr_pend = 0; rsp_pend = 0;
    forever begin
      @(negedge clk);
      mem_rd_data_valid = 1'b0;
      if (!rst_n) begin
        rd_pend = 0; wr_pend = 0; rsp_pend = 0; data_wait = -1;
      end else begin
        if (rd_pend) begin
          rd_count++;
          chk(rd_addr_c == exp_ent, "R2 entry read address", rd_addr_c, exp_ent);
          data_wait = int'($urandom % 3);
        end
        if (data_wait == 0) begin
          mem_rd_data_valid = 1'b1;
          mem_rd_data = pte_mem[cur_idx];
          data_wait = -1;
        end else if (data_wait > 0) begin
          data_wait--;
        end
        if (wr_pend) begin
          chk(wr_addr_c == exp_ent, "R8 write-back address", wr_addr_c, exp_ent);
          pte_mem[cur_idx] = wr_data_c;
          wr_count++;
        end
        if (rsp_pend) begin
          chk(rsp_fault_c == exp_fault,
              (exp_fault == 2'd1) ? "R5 fault code" : (exp_fault == 2'd2) ? "R6 fault code" : "R7 fault code",
              {30'b0, rsp_fault_c}, {30'b0, exp_fault});
          chk(rsp_paddr_c == exp_paddr, "R7 physical address", rsp_paddr_c, exp_paddr);
          chk(rsp_cache_c == exp_cache, "R7 cacheable", {31'b0, rsp_cache_c}, {31'b0, exp_cache});
          chk(wr_count == exp_wb, "R8 write-back count", wr_count, exp_wb);
          chk(pte_mem[cur_idx] == exp_pte, "R8 entry after walk", pte_mem[cur_idx], exp_pte);
          chk(rd_count == 1, "R3 one read per walk", rd_count, 1);
          rsp_count++;
        end
        mem_rd_ready = ($urandom % 4) != 0;
        mem_wr_ready = ($urandom % 3) != 0;
        rsp_ready    = ($urandom % 3) != 0;
        rd_pend  = mem_rd_valid && mem_rd_ready;
        wr_pend  = mem_wr_valid && mem_wr_ready;
        rsp_pend = rsp_valid && rsp_ready;
        rd_addr_c = mem_rd_addr;
        wr_addr_c = mem_wr_addr;
        wr_data_c = mem_wr_data;
        rsp_paddr_c = rsp_paddr;
        rsp_fault_c = rsp_fault;
        rsp_cache_c = rsp_cacheable;
      end
    end
  end

  task automatic write_base(input logic [31:0] b);
    @(negedge clk);
    base_we = 1'b1; base_wdata = b;
    @(negedge clk);
    base_we = 1'b0;
    tb_base = b;
  endtask

  task automatic xlate(input logic [31:0] va, input logic [1:0] kind, input logic [31:0] pte,
                       input bit mid_base, input logic [31:0] nb);
    int start;
    cur_idx = va[15:12];
    pte_mem[cur_idx] = pte;
    set_expect(va, kind, pte);
    wr_count = 0; rd_count = 0;
    start = rsp_count;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1 ready when idle", {31'b0, req_ready}, 32'h1);
    req_valid = 1'b1; req_vaddr = va; req_kind = kind;
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R1 busy after accept", {31'b0, req_ready}, 32'h0);
    if (mid_base) begin
      base_we = 1'b1; base_wdata = nb;
      @(negedge clk);
      base_we = 1'b0;
    end
    while (rsp_count == start) @(negedge clk);
    if (mid_base) tb_base = nb;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not complete");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] va, pte;
    logic [1:0]  kind;
    void'($urandom(32'd1237));
    rst_n = 0; base_we = 0; base_wdata = 0; req_valid = 0; req_vaddr = 0; req_kind = 0;
    tb_base = 32'h0; rsp_count = 0; wr_count = 0; rd_count = 0;
    for (int i = 0; i < 16; i++) pte_mem[i] = 32'h0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(req_ready == 1'b1, "R1 reset req_ready", {31'b0, req_ready}, 32'h1);
    chk(rsp_valid == 1'b0, "R9 reset rsp_valid", {31'b0, rsp_valid}, 32'h0);
    chk(mem_rd_valid == 1'b0 && mem_wr_valid == 1'b0, "R3 reset memory idle",
        {30'b0, mem_rd_valid, mem_wr_valid}, 32'h0);

    // R2 base resets to zero; R7/R8 read sets used bit
    xlate(32'h0000_3ABC, 2'd0, 32'h1234_5824, 0, 0);
    write_base(32'h0040_0000);
    // R8 write sets modified bit
    xlate(32'h0001_5004, 2'd1, 32'h0ABC_D80D, 0, 0);
    // R8 no write-back when flags already set
    xlate(32'h0001_5008, 2'd1, 32'h0ABC_D80F, 0, 0);
    xlate(32'h0007_7FFF, 2'd0, 32'hFFFF_F825, 0, 0);
    // R5 absent entry with all permissions
    xlate(32'h0002_2000, 2'd0, 32'h5555_503C, 0, 0);
    // R6 reserved kind and missing permissions
    xlate(32'h0002_3010, 2'd3, 32'h5555_583C, 0, 0);
    xlate(32'h0002_4010, 2'd1, 32'h5555_5804, 0, 0);
    xlate(32'h0002_5010, 2'd2, 32'h5555_580C, 0, 0);
    // R7 execute with only execute permission
    xlate(32'h0002_6123, 2'd2, 32'h0003_0830, 0, 0);
    // R4 reserved bits 10:6 carried through write-back
    xlate(32'h0002_7000, 2'd0, 32'h0009_8FC4, 0, 0);
    // R2 entry address wraps modulo 2^32
    write_base(32'hFFF0_0000);
    xlate(32'hFFFF_FFFF, 2'd0, 32'h0001_1824, 0, 0);
    // R2 base write during a walk does not affect it
    write_base(32'h0100_0000);
    xlate(32'h0003_8000, 2'd1, 32'h0004_480C, 1, 32'h0200_0000);

    for (int n = 0; n < 300; n++) begin
      va   = $urandom;
      kind = 2'($urandom % 4);
      pte  = $urandom;
      if (($urandom % 4) != 0) pte[11] = 1'b1;
      if (n % 50 == 0) write_base($urandom & 32'hFFFF_FFFC);
      xlate(va, kind, pte, (n % 37 == 5), $urandom & 32'hFFFF_FFFC);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule